// File: doc/BRIEF.md
# Writable Identity Decode Steering

This block keeps, for each hart, a writable vendor/architecture identity value and uses it to choose which of three decode engines interprets each incoming instruction word. The engines share one opcode space but read it differently: a legacy base interpretation, a current base interpretation that gives meaning to an encoding the legacy one rejects, and a custom set that adds a stateful accumulate operation on that same encoding. Software changes the interpretation with a single identity write. The next instruction of that hart then decodes under the new engine. No engine state is cleared or disabled by the switch.

Identity writes are legalised: only the three supported tuples are stored, and anything else is replaced by the base tuple. A build-time option makes the identity fixed. That configuration stands for an implementation without custom extensions, and it ignores all writes. Decode results come out one cycle after the instruction, tagged with a one-hot engine field.

Top module: `arch_id_decode_sel`

## Requirements
- R1: After reset every hart's identity reads 0x0001 (legacy base tuple), no decode result is valid, and every hart's accumulator holds 0.
- R2: With writes enabled, writing a supported tuple stores it and it reads back on `csr_rdata` for the hart on `csr_hart`. The supported tuples are 0x0001 (engine 0, tag 3'b001), 0x0002 (engine 1, tag 3'b010) and 0x5A10 (engine 2, tag 3'b100).
- R3: A write of any other value stores 0x0001 in its place, so `csr_rdata` only ever shows a supported tuple.
- R4: With `WRITABLE` = 0 the identity stays at 0x0001 whatever is written, and decode always uses engine 0.
- R5: An instruction accepted with `insn_valid` yields `dec_valid` on the next cycle, with `dec_eng` one-hot and equal to the engine chosen by that hart's identity.
- R6: The routing chosen by a write applies from the instruction presented in the cycle after the write. An instruction presented in the same cycle as the write decodes under the previous identity.
- R7: Each hart has its own identity, and decode for a hart depends only on that hart's identity.
- R8: Instruction fields are opcode [6:0], funct3 [14:12] and immediate [31:20]. Opcode 0x13 decodes in every engine to op {0,funct3}. Opcode 0x0B is illegal in engine 0, decodes to {1,funct3} in engine 1, and decodes to op 0xF in engine 2.
- R9: An encoding that the selected engine does not recognise gives `dec_illegal` = 1, with `dec_op` = 0 and `dec_data` = 0.
- R10: Engine 2's op 0xF adds the zero-extended immediate to that hart's 16-bit accumulator and returns the new value on `dec_data`. All other ops return 0 there. Identity writes never change any accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Identity write strobe |
| csr_hart | input | HART_W | Hart addressed by identity read and write |
| csr_wdata | input | 16 | Identity value to write |
| csr_rdata | output | 16 | Stored identity of the addressed hart |
| insn_valid | input | 1 | Instruction word present |
| insn_hart | input | HART_W | Hart issuing the instruction |
| insn_word | input | 32 | Instruction word |
| dec_valid | output | 1 | Decode result valid |
| dec_eng | output | 3 | One-hot tag of the engine that decoded |
| dec_hart | output | HART_W | Hart of the decoded instruction |
| dec_op | output | 4 | Decoded operation code |
| dec_illegal | output | 1 | Selected engine rejected the encoding |
| dec_data | output | 16 | Accumulator result for op 0xF, else 0 |

## Verification
The same custom-space word is decoded under all three identities. It comes out illegal, as op {1,funct3}, or as an accumulate, and that shows the routing really follows the identity. Unsupported write values and a fixed-identity instance show the legalisation and the read-only case apart from normal stores. A write in the same cycle as an instruction, followed by a repeat of that instruction, pins down the cycle in which a switch takes effect. Interleaving two harts with different identities and returning to the custom engine after switches shows that selection is per hart and that the accumulators survive.

// File: rtl/idsel_pkg.sv
package idsel_pkg;

    localparam int ID_W    = 16;
    localparam int INSN_W  = 32;
    localparam int OP_W    = 4;
    localparam int ACC_W   = 16;
    localparam int IMM_W   = 12;
    localparam int NUM_ENG = 3;

    localparam logic [6:0] OPC_ALUI = 7'h13;
    localparam logic [6:0] OPC_CUST = 7'h0B;

    localparam logic [OP_W-1:0] OP_ACC = 4'hF;

    typedef enum logic [1:0] {
        ENG_LEGACY  = 2'd0,
        ENG_CURRENT = 2'd1,
        ENG_CUSTOM  = 2'd2
    } eng_kind_e;

    // identity tuple owned by each engine: {vendor[15:8], arch[7:0]}
    function automatic logic [ID_W-1:0] eng_tuple(input int unsigned k);
        case (k)
            0:       eng_tuple = 16'h0001;
            1:       eng_tuple = 16'h0002;
            default: eng_tuple = 16'h5A10;
        endcase
    endfunction

    localparam logic [ID_W-1:0] ID_BASE = 16'h0001;

    function automatic logic [NUM_ENG-1:0] id_onehot(input logic [ID_W-1:0] t);
        logic [NUM_ENG-1:0] oh;
        oh = '0;
        for (int k = 0; k < NUM_ENG; k++) begin
            if (t == eng_tuple(k)) oh[k] = 1'b1;
        end
        return oh;
    endfunction

    function automatic logic id_is_legal(input logic [ID_W-1:0] t);
        return |id_onehot(t);
    endfunction

endpackage

// File: rtl/idsel_csr.sv
module idsel_csr
    import idsel_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter bit WRITABLE  = 1'b1,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [HART_W-1:0]                  hart,
    input  logic [ID_W-1:0]                    wdata,
    output logic [NUM_HARTS-1:0][ID_W-1:0]     id_o,
    output logic [NUM_HARTS-1:0][NUM_ENG-1:0]  sel_o
);

    typedef struct packed {
        logic [NUM_HARTS-1:0][ID_W-1:0]    id;
        logic [NUM_HARTS-1:0][NUM_ENG-1:0] sel;
    } csr_st_t;

    csr_st_t st_d, st_q;

    generate
        if (WRITABLE) begin : g_warl
            // legalise at write time so the stored one-hot is always valid
            always_comb begin
                st_d = st_q;
                if (we) begin
                    if (id_is_legal(wdata)) begin
                        st_d.id[hart]  = wdata;
                        st_d.sel[hart] = id_onehot(wdata);
                    end else begin
                        st_d.id[hart]  = ID_BASE;
                        st_d.sel[hart] = id_onehot(ID_BASE);
                    end
                end
            end
        end else begin : g_fixed
            logic unused_wr;
            assign unused_wr = ^{we, hart, wdata};
            always_comb begin
                st_d = st_q;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int h = 0; h < NUM_HARTS; h++) begin
                st_q.id[h]  <= ID_BASE;
                st_q.sel[h] <= id_onehot(ID_BASE);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign id_o  = st_q.id;
    assign sel_o = st_q.sel;

endmodule

// File: rtl/idsel_engine.sv
module idsel_engine
    import idsel_pkg::*;
#(
    parameter eng_kind_e KIND  = ENG_LEGACY,
    parameter int NUM_HARTS    = 2,
    localparam int HART_W      = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [HART_W-1:0] hart,
    input  logic [INSN_W-1:0] insn,
    output logic              hit,
    output logic [OP_W-1:0]   op,
    output logic [ACC_W-1:0]  data
);

    logic [6:0]       opc;
    logic [2:0]       f3;
    logic [IMM_W-1:0] imm;

    assign opc = insn[6:0];
    assign f3  = insn[14:12];
    assign imm = insn[31:20];

    generate
        if (KIND == ENG_CUSTOM) begin : g_custom
            logic [NUM_HARTS-1:0][ACC_W-1:0] acc_d, acc_q;
            logic [ACC_W-1:0]                sum;

            always_comb begin
                sum   = acc_q[hart] + ACC_W'(imm);
                acc_d = acc_q;
                hit   = 1'b0;
                op    = '0;
                data  = '0;
                if (opc == OPC_ALUI) begin
                    hit = 1'b1;
                    op  = {1'b0, f3};
                end else if (opc == OPC_CUST) begin
                    hit  = 1'b1;
                    op   = OP_ACC;
                    data = sum;
                    if (fire) acc_d[hart] = sum;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) acc_q <= '0;
                else     acc_q <= acc_d;
            end
        end else begin : g_plain
            logic unused_in;
            assign unused_in = ^{clk, rst, fire, hart, imm, insn[19:15], insn[11:7]};

            always_comb begin
                hit  = 1'b0;
                op   = '0;
                data = '0;
                if (opc == OPC_ALUI) begin
                    hit = 1'b1;
                    op  = {1'b0, f3};
                end else if (opc == OPC_CUST && KIND == ENG_CURRENT) begin
                    hit = 1'b1;
                    op  = {1'b1, f3};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/arch_id_decode_sel.sv
module arch_id_decode_sel
    import idsel_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter bit WRITABLE  = 1'b1,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_we,
    input  logic [HART_W-1:0]  csr_hart,
    input  logic [ID_W-1:0]    csr_wdata,
    output logic [ID_W-1:0]    csr_rdata,
    input  logic               insn_valid,
    input  logic [HART_W-1:0]  insn_hart,
    input  logic [INSN_W-1:0]  insn_word,
    output logic               dec_valid,
    output logic [NUM_ENG-1:0] dec_eng,
    output logic [HART_W-1:0]  dec_hart,
    output logic [OP_W-1:0]    dec_op,
    output logic               dec_illegal,
    output logic [ACC_W-1:0]   dec_data
);

    logic [NUM_HARTS-1:0][ID_W-1:0]    id_w;
    logic [NUM_HARTS-1:0][NUM_ENG-1:0] sel_w;
    logic [NUM_ENG-1:0]                sel;
    logic [NUM_ENG-1:0]                fire;
    logic [NUM_ENG-1:0]                hit_e;
    logic [NUM_ENG-1:0][OP_W-1:0]      op_e;
    logic [NUM_ENG-1:0][ACC_W-1:0]     data_e;

    idsel_csr #(
        .NUM_HARTS (NUM_HARTS),
        .WRITABLE  (WRITABLE)
    ) u_csr (
        .clk   (clk),
        .rst   (rst),
        .we    (csr_we),
        .hart  (csr_hart),
        .wdata (csr_wdata),
        .id_o  (id_w),
        .sel_o (sel_w)
    );

    assign csr_rdata = id_w[csr_hart];
    assign sel       = sel_w[insn_hart];
    assign fire      = insn_valid ? sel : '0;

    generate
        for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
            idsel_engine #(
                .KIND      (eng_kind_e'(e)),
                .NUM_HARTS (NUM_HARTS)
            ) u_eng (
                .clk  (clk),
                .rst  (rst),
                .fire (fire[e]),
                .hart (insn_hart),
                .insn (insn_word),
                .hit  (hit_e[e]),
                .op   (op_e[e]),
                .data (data_e[e])
            );
        end
    endgenerate

    typedef struct packed {
        logic               valid;
        logic [NUM_ENG-1:0] eng;
        logic [HART_W-1:0]  hart;
        logic [OP_W-1:0]    op;
        logic               ill;
        logic [ACC_W-1:0]   data;
    } dec_st_t;

    dec_st_t out_d, out_q;

    always_comb begin
        logic             any_hit;
        logic [OP_W-1:0]  op_m;
        logic [ACC_W-1:0] data_m;
        any_hit = 1'b0;
        op_m    = '0;
        data_m  = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            if (sel[e]) begin
                any_hit = any_hit | hit_e[e];
                op_m    = op_m | op_e[e];
                data_m  = data_m | data_e[e];
            end
        end
        out_d = '0;
        if (insn_valid) begin
            out_d.valid = 1'b1;
            out_d.eng   = sel;
            out_d.hart  = insn_hart;
            out_d.ill   = ~any_hit;
            out_d.op    = any_hit ? op_m : '0;
            out_d.data  = any_hit ? data_m : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign dec_valid   = out_q.valid;
    assign dec_eng     = out_q.eng;
    assign dec_hart    = out_q.hart;
    assign dec_op      = out_q.op;
    assign dec_illegal = out_q.ill;
    assign dec_data    = out_q.data;

endmodule

// File: rtl/arch_id_decode_sel_chk.sv
module arch_id_decode_sel_chk
    import idsel_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter bit WRITABLE  = 1'b1,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [ID_W-1:0]    csr_rdata,
    input logic               insn_valid,
    input logic               dec_valid,
    input logic [NUM_ENG-1:0] dec_eng,
    input logic [OP_W-1:0]    dec_op,
    input logic               dec_illegal,
    input logic [ACC_W-1:0]   dec_data
);

    assert_reset_default_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (csr_rdata == ID_BASE && !dec_valid));

    assert_rdata_legal_R3: assert property (@(posedge clk) disable iff (rst)
        id_is_legal(csr_rdata));

    assert_tag_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $onehot(dec_eng));

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        insn_valid |=> dec_valid);

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> !dec_valid);

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_illegal) |-> (dec_op == '0 && dec_data == '0));

    generate
        if (!WRITABLE) begin : g_ro
            assert_fixed_identity_R4: assert property (@(posedge clk) disable iff (rst)
                csr_rdata == ID_BASE);
            assert_fixed_engine_R4: assert property (@(posedge clk) disable iff (rst)
                dec_valid |-> dec_eng == 3'b001);
        end
    endgenerate

endmodule

bind arch_id_decode_sel arch_id_decode_sel_chk #(
    .NUM_HARTS (NUM_HARTS),
    .WRITABLE  (WRITABLE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_rdata   (csr_rdata),
    .insn_valid  (insn_valid),
    .dec_valid   (dec_valid),
    .dec_eng     (dec_eng),
    .dec_op      (dec_op),
    .dec_illegal (dec_illegal),
    .dec_data    (dec_data)
);

// File: tb/tb_arch_id_decode_sel.sv
module tb_arch_id_decode_sel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [0:0]  csr_hart = '0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata, ro_rdata;
    logic        insn_valid = 1'b0;
    logic [0:0]  insn_hart = '0;
    logic [31:0] insn_word = '0;
    logic        dec_valid, ro_valid;
    logic [2:0]  dec_eng, ro_eng;
    logic [0:0]  dec_hart, ro_hart;
    logic [3:0]  dec_op, ro_op;
    logic        dec_illegal, ro_illegal;
    logic [15:0] dec_data, ro_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] acc_m [2];

    always #4 clk = ~clk;

    arch_id_decode_sel #(.NUM_HARTS(2), .WRITABLE(1'b1)) dut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_hart(csr_hart),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .insn_valid(insn_valid), .insn_hart(insn_hart), .insn_word(insn_word),
        .dec_valid(dec_valid), .dec_eng(dec_eng), .dec_hart(dec_hart),
        .dec_op(dec_op), .dec_illegal(dec_illegal), .dec_data(dec_data)
    );

    arch_id_decode_sel #(.NUM_HARTS(2), .WRITABLE(1'b0)) dut_ro (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_hart(csr_hart),
        .csr_wdata(csr_wdata), .csr_rdata(ro_rdata),
        .insn_valid(insn_valid), .insn_hart(insn_hart), .insn_word(insn_word),
        .dec_valid(ro_valid), .dec_eng(ro_eng), .dec_hart(ro_hart),
        .dec_op(ro_op), .dec_illegal(ro_illegal), .dec_data(ro_data)
    );

    // {hart, write value, insn, tag, op, illegal}
    localparam int NV = 12;
    localparam logic [56:0] VEC [NV] = '{
        {1'b0, 16'h0001, 32'h0000_2013, 3'b001, 4'h2, 1'b0},
        {1'b0, 16'h0001, 32'h0030_500B, 3'b001, 4'h0, 1'b1},
        {1'b0, 16'h0002, 32'h0030_500B, 3'b010, 4'hD, 1'b0},
        {1'b0, 16'h5A10, 32'h0030_500B, 3'b100, 4'hF, 1'b0},
        {1'b0, 16'h5A10, 32'h0100_100B, 3'b100, 4'hF, 1'b0},
        {1'b0, 16'h1234, 32'h0030_500B, 3'b001, 4'h0, 1'b1},
        {1'b1, 16'h0002, 32'h0100_100B, 3'b010, 4'h9, 1'b0},
        {1'b1, 16'h5A10, 32'h0000_007F, 3'b100, 4'h0, 1'b1},
        {1'b1, 16'h5A10, 32'h0030_500B, 3'b100, 4'hF, 1'b0},
        {1'b0, 16'h5A10, 32'h0030_500B, 3'b100, 4'hF, 1'b0},
        {1'b1, 16'h0002, 32'h0000_2013, 3'b010, 4'h2, 1'b0},
        {1'b1, 16'h0001, 32'h0010_700B, 3'b001, 4'h0, 1'b1}
    };

    function automatic logic [15:0] legal_of(input logic [15:0] w);
        return (w == 16'h0001 || w == 16'h0002 || w == 16'h5A10) ? w : 16'h0001;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller sits at a negedge; returns at the next negedge
    task automatic wr_id(input logic h, input logic [15:0] w);
        csr_we = 1'b1; csr_hart = h; csr_wdata = w;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic issue(input logic h, input logic [31:0] i);
        insn_valid = 1'b1; insn_hart = h; insn_word = i;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic chk_dec(input string req, input logic h, input logic [31:0] i,
                           input logic [2:0] eng, input logic [3:0] op, input logic ill);
        logic [15:0] exp_data;
        exp_data = 16'h0;
        if (!ill && op == 4'hF) begin
            acc_m[h] = acc_m[h] + {4'h0, i[31:20]};
            exp_data = acc_m[h];
        end
        chk({req, " valid"}, {31'h0, dec_valid}, 32'h1);
        chk({req, " eng"}, {29'h0, dec_eng}, {29'h0, eng});
        chk({req, " hart"}, {31'h0, dec_hart}, {31'h0, h});
        chk({req, " op"}, {28'h0, dec_op}, {28'h0, op});
        chk({req, " illegal"}, {31'h0, dec_illegal}, {31'h0, ill});
        chk({req, " data"}, {16'h0, dec_data}, {16'h0, exp_data});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        acc_m[0] = 16'h0;
        acc_m[1] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        csr_hart = 1'b0;
        #1 chk("R1 rdata hart0", {16'h0, csr_rdata}, 32'h0001);
        csr_hart = 1'b1;
        #1 chk("R1 rdata hart1", {16'h0, csr_rdata}, 32'h0001);
        chk("R1 no valid", {31'h0, dec_valid}, 32'h0);
        @(negedge clk);

        // table: R2 R3 R5 R8 R9 R10 R7
        for (int n = 0; n < NV; n++) begin
            logic [56:0] v;
            v = VEC[n];
            wr_id(v[56], v[55:40]);
            chk("R2/R3 readback", {16'h0, csr_rdata}, {16'h0, legal_of(v[55:40])});
            issue(v[56], v[39:8]);
            chk_dec("R5/R8/R9/R10 table", v[56], v[39:8], v[7:5], v[4:1], v[0]);
            chk("R4 ro rdata", {16'h0, ro_rdata}, 32'h0001);
        end

        // R6: write and instruction in the same cycle use the old identity
        wr_id(1'b0, 16'h0002);
        csr_we = 1'b1; csr_hart = 1'b0; csr_wdata = 16'h5A10;
        issue(1'b0, 32'h0030_500B);
        csr_we = 1'b0;
        chk_dec("R6 same cycle old", 1'b0, 32'h0030_500B, 3'b010, 4'hD, 1'b0);
        issue(1'b0, 32'h0030_500B);
        chk_dec("R6 next insn new", 1'b0, 32'h0030_500B, 3'b100, 4'hF, 1'b0);

        // R7: hart1 still on legacy while hart0 is custom
        issue(1'b1, 32'h0030_500B);
        chk_dec("R7 hart1 own identity", 1'b1, 32'h0030_500B, 3'b001, 4'h0, 1'b1);
        csr_hart = 1'b0;
        #1 chk("R7 hart0 rdata", {16'h0, csr_rdata}, 32'h5A10);
        csr_hart = 1'b1;
        #1 chk("R7 hart1 rdata", {16'h0, csr_rdata}, 32'h0001);
        @(negedge clk);

        // R10: switch hart1 to custom; accumulator kept from before
        wr_id(1'b1, 16'h0002);
        wr_id(1'b1, 16'h5A10);
        issue(1'b1, 32'h0010_000B);
        chk_dec("R10 acc retained", 1'b1, 32'h0010_000B, 3'b100, 4'hF, 1'b0);

        // R4: fixed-identity instance ignores writes, decodes with engine 0
        wr_id(1'b0, 16'h5A10);
        issue(1'b0, 32'h0030_500B);
        chk("R4 ro eng", {29'h0, ro_eng}, 32'h1);
        chk("R4 ro illegal", {31'h0, ro_illegal}, 32'h1);
        chk("R4 ro data", {16'h0, ro_data}, 32'h0);
        chk("R4 ro rdata", {16'h0, ro_rdata}, 32'h0001);

        // R9 / R8: unknown opcode on current engine
        wr_id(1'b0, 16'h0002);
        issue(1'b0, 32'h0000_0063);
        chk_dec("R9 unknown on engine1", 1'b0, 32'h0000_0063, 3'b010, 4'h0, 1'b1);

        // R5: no new result without an instruction
        @(negedge clk);
        chk("R5 idle not valid", {31'h0, dec_valid}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule